// File: doc/BRIEF.md
# Switchable-Depth Receive Byte Buffer

This block holds received bytes for a 16550-style serial port until the host reads them. It has two run-time depths. In legacy mode it behaves as a single holding register that stores one byte. In FIFO mode it is a sixteen-entry circular queue. Bytes arrive on a push port from the deserializer or the loopback path. The host takes them through a pop port that is driven by reads of the data register. The head byte is visible combinationally on the pop data output, so a read sees the byte in the same cycle.

A mode-enable input selects the depth, and a flush strobe empties the buffer. Any change of the mode input empties the buffer, and the buffer then uses the new depth. While FIFO mode is on, the flush strobe empties the buffer and the depth stays at sixteen. A push into a full buffer is refused. The stored bytes are kept and an overrun pulse is raised. A ready signal tells the byte source whether a push would be accepted.

Top module: `rx_depth_fifo`

## Requirements
- R1: After reset the buffer is empty and in legacy mode (depth 1). occupancy is 0, dataReady is 0, pushReady is 1, overrun is 0 and popData is 0xFF.
- R2: The effective depth is 1 while the mode register is off and 16 while it is on. occupancy rises by one on each accepted push, falls by one on each pop of a non-empty buffer, and never exceeds the effective depth.
- R3: A clock edge at which fifoEnable differs from the mode register empties the buffer and loads the new mode. Any push or pop presented in that cycle is discarded, and it raises no overrun.
- R4: When flushReq is 1 and fifoEnable is 1, the next edge empties the buffer and the depth stays 16. When flushReq is 1 and fifoEnable is 0, the strobe has no effect.
- R5: A push presented while occupancy equals the depth is rejected and the stored bytes stay unchanged. overrun is 1 for exactly the one cycle that follows that edge.
- R6: pushReady is 1 exactly when occupancy is below the current depth. After a pop from a full buffer it is 1 again in the next cycle.
- R7: Bytes leave in the order they were accepted. The read and write positions wrap modulo the current depth, and popData shows the oldest stored byte combinationally.
- R8: A pop from an empty buffer shows 0xFF on popData and changes neither the count nor the stored order.
- R9: A push and a pop in the same cycle on a buffer that is neither empty nor full leave occupancy unchanged and append the new byte behind the remaining ones.
- R10: dataReady is 1 exactly when occupancy is non-zero. It is combinational from the stored count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Byte source offers a byte |
| pushData | input | 8 | Offered byte |
| pushReady | output | 1 | A push would be accepted |
| popReq | input | 1 | Host read of the data register removes the head byte |
| popData | output | 8 | Head byte, or 0xFF when empty |
| fifoEnable | input | 1 | 1 selects the 16-entry mode, 0 the single-entry mode |
| flushReq | input | 1 | Receiver-reset strobe, acted on only while fifoEnable is 1 |
| occupancy | output | 5 | Number of stored bytes |
| dataReady | output | 1 | Buffer holds at least one byte |
| overrun | output | 1 | One-cycle pulse after a rejected push |

## Verification
The bench goes after the edges of the depth switch. If a design kept stale bytes across a mode change, or let a push slip through during the flush cycle, a byte would appear after the change that should have been discarded. Full and empty are tested in both depths. A design that overwrote a byte on overrun would return the wrong byte on the next pop, and one that let the count wrap past the depth would show a corrupt occupancy. A design that decremented on an empty pop, or applied only one half of a simultaneous push and pop, would have its count drift away from the scoreboard. Long mixed-traffic stretches wrap the pointers many times in each mode, so a wrap at the wrong depth shows up as bytes returned out of order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Strobes handed from the control unit to the storage datapath.
  typedef struct packed {
    logic flush;  // clear pointers this edge
    logic push;   // write pushData at the write pointer
    logic pop;    // advance the read pointer
    logic wide;   // current mode: 1 = full depth, 0 = legacy depth
  } rxfStrobe_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int MAX_DEPTH    = 16,
  parameter int LEGACY_DEPTH = 1,
  localparam int CNT_W       = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             fifoEnable,
  input  logic             flushReq,
  output rxfStrobe_t       strobe,
  output logic [CNT_W-1:0] occupancy,
  output logic             pushReady,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] WIDE_DEPTH   = CNT_W'(MAX_DEPTH);
  localparam logic [CNT_W-1:0] NARROW_DEPTH = CNT_W'(LEGACY_DEPTH);

  logic             modeQ;
  logic [CNT_W-1:0] countQ;
  logic             overrunQ;

  logic [CNT_W-1:0] depthNow;
  logic             hasRoom;
  logic             isEmpty;
  logic             modeFlip;
  logic             flushNow;
  logic             pushOk;
  logic             popOk;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    depthNow = modeQ ? WIDE_DEPTH : NARROW_DEPTH;
    hasRoom  = countQ < depthNow;
    isEmpty  = countQ == '0;
    modeFlip = fifoEnable != modeQ;
    flushNow = modeFlip || (flushReq && fifoEnable);
    pushOk   = pushValid && hasRoom && !flushNow;
    popOk    = popReq && !isEmpty && !flushNow;
  end

  always_comb begin
    countNext = countQ;
    if (flushNow) begin
      countNext = '0;
    end else begin
      case ({pushOk, popOk})
        2'b10:   countNext = countQ + CNT_W'(1);
        2'b01:   countNext = countQ - CNT_W'(1);
        default: countNext = countQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      countQ   <= '0;
      overrunQ <= 1'b0;
    end else begin
      modeQ    <= fifoEnable;
      countQ   <= countNext;
      overrunQ <= pushValid && !hasRoom && !flushNow;
    end
  end

  always_comb begin
    strobe.flush = flushNow;
    strobe.push  = pushOk;
    strobe.pop   = popOk;
    strobe.wide  = modeQ;
  end

  assign occupancy = countQ;
  assign pushReady = hasRoom;
  assign overrun   = overrunQ;

endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath
  import rxf_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter int              MAX_DEPTH    = 16,
  parameter int              LEGACY_DEPTH = 1,
  parameter logic [DATA_W-1:0] EMPTY_FILL = '1,
  localparam int             PTR_W        = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxfStrobe_t        strobe,
  input  logic              holdsData,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  localparam logic [PTR_W-1:0] WIDE_LAST   = PTR_W'(MAX_DEPTH - 1);
  localparam logic [PTR_W-1:0] NARROW_LAST = PTR_W'(LEGACY_DEPTH - 1);

  logic [DATA_W-1:0]    slot [MAX_DEPTH];
  logic [MAX_DEPTH-1:0] slotWe;
  logic [PTR_W-1:0]     wrPtr;
  logic [PTR_W-1:0]     rdPtr;
  logic [PTR_W-1:0]     lastIdx;

  assign lastIdx = strobe.wide ? WIDE_LAST : NARROW_LAST;

  // One write enable per storage entry.
  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_we
    assign slotWe[g] = strobe.push && (wrPtr == PTR_W'(g));
  end

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                               input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < MAX_DEPTH; i++) begin
        if (slotWe[i]) slot[i] <= pushData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= advance(wrPtr, lastIdx);
      if (strobe.pop)  rdPtr <= advance(rdPtr, lastIdx);
    end
  end

  assign popData = holdsData ? slot[rdPtr] : EMPTY_FILL;

endmodule

// File: rtl/rx_depth_fifo.sv
module rx_depth_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MAX_DEPTH    = 16,
  parameter int LEGACY_DEPTH = 1,
  localparam int CNT_W       = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic              fifoEnable,
  input  logic              flushReq,
  output logic [CNT_W-1:0]  occupancy,
  output logic              dataReady,
  output logic              overrun
);

  rxfStrobe_t strobe;

  rxf_ctrl #(
    .MAX_DEPTH   (MAX_DEPTH),
    .LEGACY_DEPTH(LEGACY_DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .popReq    (popReq),
    .fifoEnable(fifoEnable),
    .flushReq  (flushReq),
    .strobe    (strobe),
    .occupancy (occupancy),
    .pushReady (pushReady),
    .overrun   (overrun)
  );

  assign dataReady = occupancy != '0;

  rxf_dpath #(
    .DATA_W      (DATA_W),
    .MAX_DEPTH   (MAX_DEPTH),
    .LEGACY_DEPTH(LEGACY_DEPTH),
    .EMPTY_FILL  ({DATA_W{1'b1}})
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .holdsData(dataReady),
    .pushData (pushData),
    .popData  (popData)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MAX_DEPTH = 16,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic             pushReady,
  input logic             popReq,
  input logic             fifoEnable,
  input logic             flushReq,
  input logic [CNT_W-1:0] occupancy,
  input logic             overrun
);

  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(MAX_DEPTH));

  // R3
  mode_flip_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable != $past(fifoEnable)) |=> (occupancy == '0));

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(pushValid && !pushReady));

  // R6
  ready_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReady && popReq) |=> pushReady);

  // R8
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushValid && occupancy == '0) |=> (occupancy == '0));

  // R9
  swap_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && popReq && pushReady && occupancy != '0 && !flushReq &&
     fifoEnable == $past(fifoEnable)) |=> $stable(occupancy));

endmodule

bind rx_depth_fifo rxf_checker #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pushValid (pushValid),
  .pushReady (pushReady),
  .popReq    (popReq),
  .fifoEnable(fifoEnable),
  .flushReq  (flushReq),
  .occupancy (occupancy),
  .overrun   (overrun)
);

// File: tb/tb_rx_depth_fifo.sv
`timescale 1ns/1ps
module tb_rx_depth_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic       pushReady;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic       fifoEnable = 1'b0;
  logic       flushReq = 1'b0;
  logic [4:0] occupancy;
  logic       dataReady;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard
  logic [7:0] mq[$];
  bit         mMode = 0;
  bit         mOvr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rx_depth_fifo dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushReady(pushReady), .popReq(popReq), .popData(popData),
    .fifoEnable(fifoEnable), .flushReq(flushReq), .occupancy(occupancy),
    .dataReady(dataReady), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int depthOf(input bit m);
    return m ? 16 : 1;
  endfunction

  task automatic modelUpdate(input bit pv, input logic [7:0] pd, input bit pp,
                             input bit en, input bit fl);
    bit flush;
    bit room;
    flush = (en != mMode) || (fl && en);
    room  = mq.size() < depthOf(mMode);
    if (flush) begin
      mq.delete();
      mMode = en;
      mOvr = 0;
    end else begin
      mOvr = pv && !room;
      if (pp && mq.size() > 0) void'(mq.pop_front());
      if (pv && room) mq.push_back(pd);
    end
  endtask

  task automatic compareAll();
    chk("R2 occupancy", int'(occupancy), mq.size());
    chk("R10 dataReady", int'(dataReady), int'(mq.size() != 0));
    chk("R6 pushReady", int'(pushReady), int'(mq.size() < depthOf(mMode)));
    chk("R7 popData", int'(popData), (mq.size() != 0) ? int'(mq[0]) : 255);
    chk("R5 overrun", int'(overrun), int'(mOvr));
  endtask

  task automatic step(input bit pv, input logic [7:0] pd, input bit pp,
                      input bit en, input bit fl);
    @(negedge clk);
    pushValid = pv; pushData = pd; popReq = pp; fifoEnable = en; flushReq = fl;
    @(posedge clk);
    modelUpdate(pv, pd, pp, en, fl);
    #2;
    compareAll();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 dataReady", int'(dataReady), 0);
    chk("R1 pushReady", int'(pushReady), 1);
    chk("R1 popData", int'(popData), 255);
    chk("R1 overrun", int'(overrun), 0);

    // Legacy depth: one byte, second push overruns
    step(1, 8'h41, 0, 0, 0);
    step(1, 8'h42, 0, 0, 0);
    chk("R5 kept byte", int'(popData), 8'h41);
    step(0, 8'h00, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    chk("R5 pulse one cycle", int'(overrun), 0);
    // R4 flush strobe ignored in legacy mode
    step(0, 8'h00, 0, 0, 1);
    chk("R4 ignored flush", int'(occupancy), 1);
    step(0, 8'h00, 1, 0, 0);
    // R8 pop when empty
    step(0, 8'h00, 1, 0, 0);
    chk("R8 empty pop data", int'(popData), 255);
    chk("R8 empty pop count", int'(occupancy), 0);

    // Leave a byte, then switch mode while pushing: R3
    step(1, 8'h10, 0, 0, 0);
    step(1, 8'h11, 0, 1, 0);
    chk("R3 flush on enable", int'(occupancy), 0);
    chk("R3 no overrun", int'(overrun), 0);

    // Fill to 16, then overrun and full pop
    for (int i = 0; i < 16; i++) step(1, 8'(8'h80 + i), 0, 1, 0);
    chk("R2 depth 16", int'(occupancy), 16);
    step(1, 8'hEE, 0, 1, 0);
    chk("R5 full overrun", int'(overrun), 1);
    step(1, 8'hEF, 1, 1, 0);
    chk("R6 ready after pop", int'(pushReady), 1);
    // R9 push+pop on partially filled buffer
    step(1, 8'h55, 1, 1, 0);
    chk("R9 count kept", int'(occupancy), 15);
    // R4 flush in FIFO mode keeps depth 16
    step(0, 8'h00, 0, 1, 1);
    chk("R4 flush empties", int'(occupancy), 0);
    for (int i = 0; i < 16; i++) step(1, 8'(i * 7), 0, 1, 0);
    chk("R4 depth kept", int'(occupancy), 16);
    // R3 disable with data inside
    step(0, 8'h00, 1, 0, 0);
    chk("R3 flush on disable", int'(occupancy), 0);

    // Mixed traffic sweep: alternating modes and pop pressure
    for (int seg = 0; seg < 12; seg++) begin
      bit en;
      en = (seg % 3) != 2;
      for (int c = 0; c < 250; c++) begin
        bit pv;
        bit pp;
        bit fl;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pv = lfsr[0] | lfsr[1];
        case (seg % 4)
          0: pp = lfsr[2] & lfsr[3];
          1: pp = lfsr[2] | lfsr[3];
          2: pp = lfsr[2];
          default: pp = lfsr[2] & lfsr[3] & lfsr[4];
        endcase
        fl = (lfsr[11:5] == 7'h2A);
        step(pv, lfsr[15:8], pp, en, fl);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule